// File: doc/BRIEF.md
# Width-Configurable Byte-Pool FIFO

This block is the data queue that sits between a serial shift engine and a register bus. It keeps a fixed pool of bytes (256 by default). Software picks at run time whether each entry is one, two or four bytes wide. The number of entries the pool can hold therefore changes with that choice: 256, 128 or 64.

A build parameter picks the side of the serial link the queue serves:
- **Receive (default):** the engine pushes entries on the line port, and software drains them by reading the data register.
- **Transmit:** software fills the queue through the data register, and the engine drains it on the line port.

The block also provides:
- **Run control:** software can empty the queue in one cycle and can start or stop it.
- **Threshold events:** an 8-bit entry threshold drives rising and falling threshold events.
- **Word watermarks:** three watermarks, counted in 32-bit words, drive level flags toward a transfer engine.
- **Interrupt:** four events go into a write-one-to-clear status register, and a maskable interrupt is formed from them.

Top module: `fifo_bytepool`

## Requirements
- R1: After reset, the status register (address 2) reads 0x200: empty set, full clear, level 0. The operation register (address 1) reads 0, `line_ready` is low and `irq` is low.
- R2: Control register (address 0) bits 1:0 select the entry width: 0 for 8-bit, 1 for 16-bit, and 2 (or 3) for 32-bit entries. The capacity is 256 bytes divided by the entry size. Full is reported once that many entries are held.
- R3: Entries leave in the order they entered. The data register (address 4) returns the oldest entry, zero-extended above the selected width.
- R4: While the run bit is clear, pushes are ignored, reads of the data register remove nothing, and `line_ready` is low. Held data is kept.
- R5: Writing the operation register with bit 0 set empties the queue. After the next clock edge the level is 0 and empty is set. Bit 1 of the same write sets the run bit.
- R6: A push while full or a pop while empty is ignored, and the level does not change.
- R7: The status register reports the level in entries in bits 7:0, full in bit 8 and empty in bit 9.
- R8: The event register (address 5) sets bit 8 when the condition "level ≥ threshold" becomes true. It sets bit 9 when "level ≤ threshold" becomes true. The threshold is control bits 9:2, counted in entries.
- R9: Event bit 6 sets when the queue becomes full. Event bit 7 sets when it becomes empty.
- R10: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as its clear wins.
- R11: `irq` is high exactly when some event bit is set and its enable bit is also set. The enable register is address 6, using the same bit positions. An all-zero enable keeps `irq` low.
- R12: The watermark register (address 3) holds three 6-bit word counts, at bits 5:0, 15:10 and 25:20. `mark_hit[i]` is high when the stored byte count divided by 4 is at least watermark i.
- R13: The control, watermark and operation registers read back what was last written. The operation register returns the run bit in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the access cycle |
| line_push | input | 1 | Engine push (receive build) |
| line_wdata | input | 32 | Engine push data |
| line_ready | output | 1 | Queue accepts engine pushes |
| line_pop | input | 1 | Engine pop (transmit build) |
| line_rdata | output | 32 | Oldest entry toward the engine |
| line_valid | output | 1 | An entry is available to the engine |
| irq | output | 1 | Masked event interrupt |
| mark_hit | output | 3 | Watermark flags |

## Verification
The assertions assume that entry width is not changed while odd bytes of an older width remain in the pool. If that happened, full and empty could be judged on a partial entry. They also assume that a data-register access lasts exactly one cycle, since every `reg_sel` read of the data address pops.

The stimulus meets both assumptions. Every register access is a single-cycle strobe followed by an idle cycle. Each width change is made only when the queue is empty or has just been reset through the operation register.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned LANES  = REG_W / 8;
  localparam int unsigned NBW    = $clog2(LANES) + 1;
  localparam int unsigned N_EVT  = 4;
  localparam int unsigned EVT_LSB = 6;
  localparam int unsigned N_MARK = 3;
  localparam int unsigned MARK_W = 6;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_OP    = 3'd1,
    RA_STAT  = 3'd2,
    RA_MARKS = 3'd3,
    RA_DATA  = 3'd4,
    RA_EVT   = 3'd5,
    RA_EVTEN = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    EW_BYTE = 2'd0,
    EW_HALF = 2'd1,
    EW_WORD = 2'd2,
    EW_WIDE = 2'd3
  } ent_width_e;

  typedef struct packed {
    logic [7:0] thr;
    ent_width_e width;
  } ctrl_t;

  // log2 of entry size in bytes; the spare code behaves as 32-bit
  function automatic logic [1:0] width_shift(ent_width_e w);
    case (w)
      EW_BYTE: width_shift = 2'd0;
      EW_HALF: width_shift = 2'd1;
      default: width_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/fbp_store.sv
`timescale 1ns/1ps
module fbp_store
  import fbp_pkg::*;
#(
  parameter int unsigned DEPTH_B = 256
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    push,
  input  logic                    pop,
  input  logic [NBW-1:0]          nbytes,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  output logic [$clog2(DEPTH_B):0] used,
  output logic                    full,
  output logic                    empty
);
  localparam int unsigned PW = $clog2(DEPTH_B);
  localparam int unsigned CW = PW + 1;

  logic [7:0]    mem [DEPTH_B];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] used_q, used_d;
  logic          room, avail, do_push, do_pop;

  always_comb begin
    room    = (CW'(DEPTH_B) - used_q) >= CW'(nbytes);
    avail   = used_q >= CW'(nbytes);
    do_push = push && room;
    do_pop  = pop && avail;
    wr_d    = wr_q;
    rd_d    = rd_q;
    used_d  = used_q;
    if (clr) begin
      wr_d   = '0;
      rd_d   = '0;
      used_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + PW'(nbytes);
      if (do_pop)  rd_d = rd_q + PW'(nbytes);
      used_d = used_q + (do_push ? CW'(nbytes) : CW'(0))
                      - (do_pop  ? CW'(nbytes) : CW'(0));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      used_q <= '0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      used_q <= used_d;
    end
  end

  // byte lanes written with an explicit enable; storage carries no reset
  always_ff @(posedge clk) begin
    if (do_push && !clr) begin
      for (int k = 0; k < LANES; k++) begin
        if (NBW'(k) < nbytes) mem[wr_q + PW'(k)] <= wdata[8*k +: 8];
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rlane
    logic [PW-1:0] ra;
    assign ra = rd_q + PW'(g);
    assign rdata[8*g +: 8] = (NBW'(g) < nbytes) ? mem[ra] : 8'h00;
  end

  assign used  = used_q;
  assign full  = !room;
  assign empty = !avail;
endmodule

// File: rtl/fbp_cfg.sv
`timescale 1ns/1ps
module fbp_cfg
  import fbp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_ctrl,
  input  logic                          wr_op,
  input  logic                          wr_marks,
  input  logic [15:0]                   wlo,
  input  logic [MARK_W-1:0]             whi,
  output ctrl_t                         ctrl,
  output logic                          run,
  output logic                          clr,
  output logic [N_MARK-1:0][MARK_W-1:0] marks
);
  ctrl_t                         ctrl_q, ctrl_d;
  logic                          run_q, run_d;
  logic [N_MARK-1:0][MARK_W-1:0] marks_q, marks_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    run_d   = run_q;
    marks_d = marks_q;
    if (wr_ctrl) ctrl_d = ctrl_t'(wlo[9:0]);
    if (wr_op)   run_d  = wlo[1];
    if (wr_marks) begin
      marks_d[0] = wlo[5:0];
      marks_d[1] = wlo[15:10];
      marks_d[2] = whi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      run_q   <= 1'b0;
      marks_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      run_q   <= run_d;
      marks_q <= marks_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign run   = run_q;
  assign marks = marks_q;
  assign clr   = wr_op && wlo[0];
endmodule

// File: rtl/fbp_events.sv
`timescale 1ns/1ps
module fbp_events
  import fbp_pkg::*;
#(
  parameter int unsigned CW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full,
  input  logic             empty,
  input  logic [CW-1:0]    level,
  input  logic [7:0]       thr,
  input  logic             clr_we,
  input  logic             en_we,
  input  logic [N_EVT-1:0] wbits,
  output logic [N_EVT-1:0] evt,
  output logic [N_EVT-1:0] en,
  output logic             irq
);
  // index 0 full, 1 empty, 2 level at/above threshold, 3 level at/below threshold
  logic [N_EVT-1:0] cond, fire, prev_q, prev_d, evt_q, evt_d, en_q, en_d;

  always_comb begin
    cond[0] = full;
    cond[1] = empty;
    cond[2] = level >= CW'(thr);
    cond[3] = level <= CW'(thr);
    fire    = cond & ~prev_q;
    prev_d  = cond;
    evt_d   = evt_q;
    if (clr_we) evt_d = evt_d & ~wbits;
    evt_d   = evt_d | fire;
    en_d    = en_we ? wbits : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 4'b1110;
      evt_q  <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= prev_d;
      evt_q  <= evt_d;
      en_q   <= en_d;
    end
  end

  assign evt = evt_q;
  assign en  = en_q;
  assign irq = |(evt_q & en_q);
endmodule

// File: rtl/fifo_bytepool.sv
`timescale 1ns/1ps
module fifo_bytepool
  import fbp_pkg::*;
#(
  parameter int unsigned DEPTH_B = 256,
  parameter bit          SIDE_TX = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              line_push,
  input  logic [REG_W-1:0]  line_wdata,
  output logic              line_ready,
  input  logic              line_pop,
  output logic [REG_W-1:0]  line_rdata,
  output logic              line_valid,
  output logic              irq,
  output logic [N_MARK-1:0] mark_hit
);
  localparam int unsigned PW = $clog2(DEPTH_B);
  localparam int unsigned CW = PW + 1;

  reg_addr_e                     ra;
  logic                          wr_hit, rd_hit;
  ctrl_t                         ctrl;
  logic                          run, clr;
  logic [N_MARK-1:0][MARK_W-1:0] marks;
  logic [1:0]                    shift;
  logic [NBW-1:0]                nbytes;
  logic                          host_push, host_pop, eng_push, eng_pop;
  logic                          st_push, st_pop, st_full, st_empty;
  logic [REG_W-1:0]              st_wdata, st_rdata;
  logic [CW-1:0]                 st_used, level, words;
  logic [N_EVT-1:0]              evt, en;

  assign ra     = reg_addr_e'(reg_addr);
  assign wr_hit = reg_sel && reg_we;
  assign rd_hit = reg_sel && !reg_we;

  fbp_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_hit && ra == RA_CTRL),
    .wr_op    (wr_hit && ra == RA_OP),
    .wr_marks (wr_hit && ra == RA_MARKS),
    .wlo      (reg_wdata[15:0]),
    .whi      (reg_wdata[25:20]),
    .ctrl     (ctrl),
    .run      (run),
    .clr      (clr),
    .marks    (marks)
  );

  assign shift  = width_shift(ctrl.width);
  assign nbytes = NBW'(1) << shift;

  assign host_push = run && wr_hit && ra == RA_DATA;
  assign host_pop  = run && rd_hit && ra == RA_DATA;
  assign eng_push  = run && line_push;
  assign eng_pop   = run && line_pop;

  // side selection: who fills and who drains
  assign st_push    = SIDE_TX ? host_push : eng_push;
  assign st_pop     = SIDE_TX ? eng_pop   : host_pop;
  assign st_wdata   = SIDE_TX ? reg_wdata : line_wdata;
  assign line_ready = SIDE_TX ? 1'b0 : (run && !st_full);
  assign line_valid = SIDE_TX ? (run && !st_empty) : 1'b0;
  assign line_rdata = SIDE_TX ? st_rdata : '0;

  fbp_store #(.DEPTH_B(DEPTH_B)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .push   (st_push),
    .pop    (st_pop),
    .nbytes (nbytes),
    .wdata  (st_wdata),
    .rdata  (st_rdata),
    .used   (st_used),
    .full   (st_full),
    .empty  (st_empty)
  );

  assign level = st_used >> shift;
  assign words = st_used >> 2;

  for (genvar i = 0; i < N_MARK; i++) begin : g_mark
    assign mark_hit[i] = words >= CW'(marks[i]);
  end

  fbp_events #(.CW(CW)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .full   (st_full),
    .empty  (st_empty),
    .level  (level),
    .thr    (ctrl.thr),
    .clr_we (wr_hit && ra == RA_EVT),
    .en_we  (wr_hit && ra == RA_EVTEN),
    .wbits  (reg_wdata[EVT_LSB +: N_EVT]),
    .evt    (evt),
    .en     (en),
    .irq    (irq)
  );

  always_comb begin
    case (ra)
      RA_CTRL:  reg_rdata = {22'b0, ctrl};
      RA_OP:    reg_rdata = {30'b0, run, 1'b0};
      RA_STAT:  reg_rdata = {22'b0, st_empty, st_full, level[7:0]};
      RA_MARKS: reg_rdata = {6'b0, marks[2], 4'b0, marks[1], 4'b0, marks[0]};
      RA_DATA:  reg_rdata = st_rdata;
      RA_EVT:   reg_rdata = {22'b0, evt, 6'b0};
      RA_EVTEN: reg_rdata = {22'b0, en, 6'b0};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fbp_chk.sv
`timescale 1ns/1ps
module fbp_chk #(
  parameter int unsigned CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          clr,
  input logic          push,
  input logic          pop,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] used,
  input logic          evt_full,
  input logic [3:0]    en,
  input logic          irq
);
  a_r5_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (used == '0 && empty && !full));

  a_r4_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(used));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> $stable(used));

  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !clr) |=> $stable(used));

  a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r9_full_event: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |=> evt_full);

  a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en == 4'b0) |-> !irq);
endmodule

bind fifo_bytepool fbp_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .clr      (clr),
  .push     (st_push),
  .pop      (st_pop),
  .full     (st_full),
  .empty    (st_empty),
  .used     (st_used),
  .evt_full (evt[0]),
  .en       (en),
  .irq      (irq)
);

// File: tb/sim_fifo_bytepool.sv
`timescale 1ns/1ps
module sim_fifo_bytepool;
  import fbp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        line_push = 1'b0, line_pop = 1'b0;
  logic [31:0] line_wdata = '0, line_rdata;
  logic        line_ready, line_valid, irq;
  logic [2:0]  mark_hit;

  int          n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  int          ew_bytes = 1;
  bit          running = 1'b0;

  always #2.5 clk = ~clk;

  fifo_bytepool u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_push(line_push), .line_wdata(line_wdata), .line_ready(line_ready),
    .line_pop(line_pop), .line_rdata(line_rdata), .line_valid(line_valid),
    .irq(irq), .mark_hit(mark_hit)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    #0.5 d = reg_rdata;
    @(negedge clk); reg_sel = 1'b0;
  endtask

  task automatic expect_stat(input string req, input bit e, input bit f, input logic [7:0] lvl);
    logic [31:0] d;
    reg_read(RA_STAT, d);
    check(req, d, {22'b0, e, f, lvl});
  endtask

  // driver: engine-side push, expected item queued when the model accepts it
  task automatic drive_item(input logic [31:0] d);
    int cap = 256 / ew_bytes;
    logic [31:0] m = (ew_bytes == 4) ? d : (ew_bytes == 2) ? {16'h0, d[15:0]} : {24'h0, d[7:0]};
    @(negedge clk); line_push = 1'b1; line_wdata = d;
    @(negedge clk); line_push = 1'b0;
    if (running && exp_q.size() < cap) exp_q.push_back(m);
  endtask

  // monitor: pop through the data register and compare to the scoreboard
  task automatic take_item(input string req);
    logic [31:0] d;
    reg_read(RA_DATA, d);
    if (running && exp_q.size() > 0) check(req, d, exp_q.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_stat("R1 status", 1'b1, 1'b0, 8'd0);
    check("R1 line_ready", {31'b0, line_ready}, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    reg_read(RA_OP, d);
    check("R1 op", d, 32'h0);

    // R4 push while stopped is dropped
    drive_item(32'hAA);
    expect_stat("R4 stopped push", 1'b1, 1'b0, 8'd0);

    // byte entries, threshold 3
    reg_write(RA_CTRL, {22'b0, 8'd3, 2'd0}); ew_bytes = 1;
    reg_read(RA_CTRL, d);
    check("R13 ctrl readback", d, 32'h00C);
    reg_write(RA_OP, 32'h2); running = 1'b1;
    check("R4 ready when running", {31'b0, line_ready}, 32'h1);
    reg_write(RA_EVT, 32'h3C0);
    drive_item(32'h11); drive_item(32'h22); drive_item(32'h33);
    expect_stat("R7 level 3", 1'b0, 1'b0, 8'd3);
    reg_read(RA_EVT, d);
    check("R8 rise threshold", d, 32'h100);
    reg_write(RA_EVT, 32'h100);
    reg_read(RA_EVT, d);
    check("R10 w1c", d, 32'h0);
    take_item("R3 byte order"); take_item("R3 byte order"); take_item("R3 byte order");
    expect_stat("R7 empty", 1'b1, 1'b0, 8'd0);
    reg_read(RA_EVT, d);
    check("R9 empty event", d, 32'h080);
    take_item("R6 underflow");
    expect_stat("R6 underflow level", 1'b1, 1'b0, 8'd0);

    // 16-bit entries
    reg_write(RA_CTRL, 32'h1); ew_bytes = 2;
    reg_write(RA_EVT, 32'h3C0);
    drive_item(32'hFFFFBEEF); drive_item(32'h00A51234);
    expect_stat("R2 half level", 1'b0, 1'b0, 8'd2);
    take_item("R3 half zero-extend"); take_item("R3 half order");

    // 32-bit entries, fill to capacity
    reg_write(RA_CTRL, 32'h2); ew_bytes = 4;
    reg_write(RA_MARKS, {6'b0, 6'd60, 4'b0, 6'd32, 4'b0, 6'd4});
    reg_read(RA_MARKS, d);
    check("R13 marks readback", d, {6'b0, 6'd60, 4'b0, 6'd32, 4'b0, 6'd4});
    reg_write(RA_EVT, 32'h3C0);
    check("R12 marks idle", {29'b0, mark_hit}, 32'h0);
    for (int i = 0; i < 64; i++) begin
      drive_item(32'hC0DE0000 + i);
      if (i == 9)  check("R12 low mark", {29'b0, mark_hit}, 32'h1);
      if (i == 39) check("R12 mid mark", {29'b0, mark_hit}, 32'h3);
    end
    check("R12 all marks", {29'b0, mark_hit}, 32'h7);
    expect_stat("R2 word full", 1'b0, 1'b1, 8'd64);
    check("R6 ready low when full", {31'b0, line_ready}, 32'h0);
    drive_item(32'hDEAD0000);
    expect_stat("R6 overflow ignored", 1'b0, 1'b1, 8'd64);
    reg_read(RA_EVT, d);
    check("R9 full event", d, 32'h040);
    reg_write(RA_EVTEN, 32'h040);
    check("R11 irq enabled", {31'b0, irq}, 32'h1);
    reg_write(RA_EVTEN, 32'h0);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
    reg_write(RA_EVT, 32'h3C0);
    for (int i = 0; i < 64; i++) take_item("R3 word order");
    expect_stat("R7 drained", 1'b1, 1'b0, 8'd0);
    reg_read(RA_EVT, d);
    check("R8 R9 fall and empty", d, 32'h280);
    reg_write(RA_EVTEN, 32'h200);
    check("R11 irq fall event", {31'b0, irq}, 32'h1);
    reg_write(RA_EVT, 32'h200);
    check("R10 R11 cleared bit drops irq", {31'b0, irq}, 32'h0);
    reg_write(RA_EVTEN, 32'h0);

    // stop keeps data, reset empties it
    drive_item(32'h1); drive_item(32'h2);
    reg_write(RA_OP, 32'h0); running = 1'b0;
    drive_item(32'h3);
    expect_stat("R4 stopped push kept", 1'b0, 1'b0, 8'd2);
    take_item("R4 stopped read");
    expect_stat("R4 stopped read no pop", 1'b0, 1'b0, 8'd2);
    check("R4 ready low stopped", {31'b0, line_ready}, 32'h0);
    reg_write(RA_OP, 32'h3); running = 1'b1; exp_q.delete();
    expect_stat("R5 reset empties", 1'b1, 1'b0, 8'd0);
    reg_read(RA_OP, d);
    check("R13 op readback", d, 32'h2);
    drive_item(32'h55AA7733);
    take_item("R5 order after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule